// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block is a single copy channel that moves data between two descriptor rings stored in one word-addressed memory. Software places source descriptors, each naming a buffer, a byte count and flags, into the source ring. It places empty receive buffers into the destination ring, then advances the write index of each ring through a small register port. The engine follows the two rings, copies whole words from each source buffer into the current destination buffer, and reports progress through read indices that software can read back.

Several source fragments can be chained into one destination buffer with the gather flag. A destination descriptor counts as finished once the engine has written a non-zero received length into it. The engine then advances its destination read index and raises a one-cycle completion pulse. A source descriptor that asks for more bytes than the programmed limit is dropped, and a sticky error bit records the event.

Top module: `ce_copy_engine`

## Requirements
- R1: After reset both read indices and both write indices read 0, the error bit reads 0, both ring size registers read 1, and `copy_done` is low.
- R2: Descriptor `i` of a ring occupies words `base+2*i` and `base+2*i+1`. The first word holds the buffer word address. In the second word, bits [15:0] hold the byte count, bit 16 is gather and bit 17 is byte swap. Bits [31:20] carry a transfer id that has no effect on the copy.
- R3: The engine starts a descriptor only while the source read index differs from the source write index and a destination buffer is either still open from a gather or pending, meaning the destination read index differs from the destination write index. Otherwise it leaves both indices and memory untouched.
- R4: A descriptor with byte count `n` copies `ceil(n/4)` words, in order, from its buffer address to consecutive words of the destination buffer.
- R5: When the swap bit is set, each copied word has its four bytes in reverse order. When the swap bit is clear, each word is copied unchanged.
- R6: A descriptor with the gather bit set leaves the destination buffer open. The next descriptor's words follow directly after it, and only a descriptor without gather completes the buffer, producing a single completion.
- R7: On completion the engine writes `{16'h0, total byte count}` into word 1 of the destination descriptor. In the cycle after that write, the destination read index shows its incremented value and `copy_done` is high for exactly that one cycle. The destination read index changes at no other time.
- R8: The source read index steps by one for every source descriptor consumed, whether it was copied or dropped.
- R9: Indices wrap modulo the ring size, a power of two. A value written to a write index register is stored ANDed with size-1. Keeping one slot empty, a 4-entry ring runs through index 3 back to 0.
- R10: A source descriptor whose byte count exceeds the maximum length register is skipped: no memory copy, no destination change, and the error bit becomes 1. The error bit stays 1 until software writes 1 to bit 0 of the status register.
- R11: Register word addresses: 0 source base, 1 source size, 2 source write index, 3 source read index (read only), 4 destination base, 5 destination size, 6 destination write index, 7 destination read index (read only), 8 maximum length, 9 status (bit 0 error, write 1 to clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable when requesting |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| copy_done | output | 1 | One-cycle pulse per completed destination buffer |
| err_flag | output | 1 | Sticky over-length error |

## Verification
The bench aims at the gather merge, where a wrong design would produce two completions or write the second fragment over the first. It also targets a source descriptor with no destination buffer posted: an eager engine would write through a stale destination pointer. An over-length descriptor must advance only the source index and leave the destination buffer intact, and the error bit must stay set until it is cleared. A non-multiple-of-four length and a wrap of both rings through index 3 catch a round-down word count and a missing index mask. A masked write of an out-of-range index value catches the same mask fault on the register side.

// File: rtl/ce_pkg.sv
package ce_pkg;

  // register word addresses
  localparam logic [3:0] RA_SRC_BASE = 4'd0;
  localparam logic [3:0] RA_SRC_SIZE = 4'd1;
  localparam logic [3:0] RA_SRC_WR   = 4'd2;
  localparam logic [3:0] RA_SRC_RD   = 4'd3;
  localparam logic [3:0] RA_DST_BASE = 4'd4;
  localparam logic [3:0] RA_DST_SIZE = 4'd5;
  localparam logic [3:0] RA_DST_WR   = 4'd6;
  localparam logic [3:0] RA_DST_RD   = 4'd7;
  localparam logic [3:0] RA_MAX_LEN  = 4'd8;
  localparam logic [3:0] RA_STATUS   = 4'd9;

  // flag positions inside descriptor word 1
  localparam int FB_GATHER = 16;
  localparam int FB_SWAP   = 17;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SA, ST_SC, ST_SCW, ST_DA, ST_DAW,
    ST_CRD, ST_CWR, ST_SDONE, ST_WB
  } walk_state_t;

  // word address of word w of descriptor idx in a ring at base
  function automatic logic [31:0] desc_loc(logic [31:0] base, logic [15:0] idx, logic w);
    return base + {15'd0, idx, w};
  endfunction

  // next ring slot with wrap
  function automatic logic [15:0] ring_step(logic [15:0] idx, logic [15:0] mask);
    return (idx + 16'd1) & mask;
  endfunction

  // whole words needed for a byte count
  function automatic logic [15:0] words_of(logic [15:0] nbytes);
    return 16'((17'(nbytes) + 17'd3) >> 2);
  endfunction

endpackage

// File: rtl/ce_word_swap.sv
module ce_word_swap #(
  parameter int DW = 32
) (
  input  logic          swap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = swap_en ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/ce_regs.sv
module ce_regs
  import ce_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [IDX_W-1:0] src_rd,
  input  logic [IDX_W-1:0] dst_rd,
  input  logic             err_set,
  output logic [AW-1:0]    src_base,
  output logic [AW-1:0]    dst_base,
  output logic [IDX_W-1:0] src_mask,
  output logic [IDX_W-1:0] dst_mask,
  output logic [IDX_W-1:0] src_wr,
  output logic [IDX_W-1:0] dst_wr,
  output logic [15:0]      max_len,
  output logic             err_flag,
  output logic             err_clr
);
  localparam int SZ_W = IDX_W + 1;

  logic [SZ_W-1:0] src_size, dst_size;

  assign src_mask = IDX_W'(src_size - SZ_W'(1));
  assign dst_mask = IDX_W'(dst_size - SZ_W'(1));
  assign err_clr  = reg_wr && (reg_addr == RA_STATUS) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      src_size <= SZ_W'(1);
      dst_size <= SZ_W'(1);
      src_wr   <= '0;
      dst_wr   <= '0;
      max_len  <= '0;
      err_flag <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_SRC_BASE: src_base <= reg_wdata[AW-1:0];
          RA_SRC_SIZE: src_size <= reg_wdata[SZ_W-1:0];
          RA_SRC_WR:   src_wr   <= reg_wdata[IDX_W-1:0] & src_mask;
          RA_DST_BASE: dst_base <= reg_wdata[AW-1:0];
          RA_DST_SIZE: dst_size <= reg_wdata[SZ_W-1:0];
          RA_DST_WR:   dst_wr   <= reg_wdata[IDX_W-1:0] & dst_mask;
          RA_MAX_LEN:  max_len  <= reg_wdata[15:0];
          default: ;
        endcase
      end
      if (err_set)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_SRC_BASE: reg_rdata = 32'(src_base);
      RA_SRC_SIZE: reg_rdata = 32'(src_size);
      RA_SRC_WR:   reg_rdata = 32'(src_wr);
      RA_SRC_RD:   reg_rdata = 32'(src_rd);
      RA_DST_BASE: reg_rdata = 32'(dst_base);
      RA_DST_SIZE: reg_rdata = 32'(dst_size);
      RA_DST_WR:   reg_rdata = 32'(dst_wr);
      RA_DST_RD:   reg_rdata = 32'(dst_rd);
      RA_MAX_LEN:  reg_rdata = 32'(max_len);
      RA_STATUS:   reg_rdata = 32'(err_flag);
      default:     reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/ce_ring_walker.sv
module ce_ring_walker
  import ce_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [IDX_W-1:0] src_mask,
  input  logic [IDX_W-1:0] dst_mask,
  input  logic [IDX_W-1:0] src_wr,
  input  logic [IDX_W-1:0] dst_wr,
  input  logic [15:0]      max_len,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [IDX_W-1:0] src_rd,
  output logic [IDX_W-1:0] dst_rd,
  output logic             copy_done,
  output logic             err_set,
  output logic             busy,
  output logic             wb_fire
);
  walk_state_t state;
  logic [AW-1:0] s_addr, d_ptr;
  logic [15:0]   s_cnt, acc, widx, nwords;
  logic          s_gather, s_swap, d_open;
  logic [31:0]   swapped;
  logic          src_pend, dst_pend, too_long;

  ce_word_swap #(.DW(32)) u_swap (.swap_en(s_swap), .din(mem_rdata), .dout(swapped));

  assign src_pend = (src_rd != src_wr);
  assign dst_pend = (dst_rd != dst_wr);
  assign too_long = (mem_rdata[15:0] > max_len);
  assign busy     = (state != ST_IDLE);
  assign err_set  = (state == ST_SCW) && too_long;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    wb_fire   = 1'b0;
    case (state)
      ST_SA: begin
        mem_req  = 1'b1;
        mem_addr = AW'(desc_loc(32'(src_base), 16'(src_rd), 1'b0));
      end
      ST_SC: begin
        mem_req  = 1'b1;
        mem_addr = AW'(desc_loc(32'(src_base), 16'(src_rd), 1'b1));
      end
      ST_DA: begin
        mem_req  = 1'b1;
        mem_addr = AW'(desc_loc(32'(dst_base), 16'(dst_rd), 1'b0));
      end
      ST_CRD: begin
        mem_req  = 1'b1;
        mem_addr = AW'(32'(s_addr) + 32'(widx));
      end
      ST_CWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = d_ptr;
        mem_wdata = swapped;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(desc_loc(32'(dst_base), 16'(dst_rd), 1'b1));
        mem_wdata = {16'h0, acc};
        wb_fire   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      s_addr    <= '0;
      d_ptr     <= '0;
      s_cnt     <= '0;
      acc       <= '0;
      widx      <= '0;
      nwords    <= '0;
      s_gather  <= 1'b0;
      s_swap    <= 1'b0;
      d_open    <= 1'b0;
      src_rd    <= '0;
      dst_rd    <= '0;
      copy_done <= 1'b0;
    end else begin
      copy_done <= 1'b0;
      case (state)
        ST_IDLE: if (src_pend && (d_open || dst_pend)) state <= ST_SA;
        ST_SA:   state <= ST_SC;
        ST_SC: begin
          s_addr <= AW'(mem_rdata);
          state  <= ST_SCW;
        end
        ST_SCW: begin
          s_cnt    <= mem_rdata[15:0];
          s_gather <= mem_rdata[FB_GATHER];
          s_swap   <= mem_rdata[FB_SWAP];
          nwords   <= words_of(mem_rdata[15:0]);
          widx     <= '0;
          if (too_long) begin
            src_rd <= IDX_W'(ring_step(16'(src_rd), 16'(src_mask)));
            state  <= ST_IDLE;
          end else if (!d_open) begin
            state <= ST_DA;
          end else begin
            state <= (mem_rdata[15:0] == 16'd0) ? ST_SDONE : ST_CRD;
          end
        end
        ST_DA: state <= ST_DAW;
        ST_DAW: begin
          d_ptr  <= AW'(mem_rdata);
          d_open <= 1'b1;
          acc    <= '0;
          state  <= (nwords == 16'd0) ? ST_SDONE : ST_CRD;
        end
        ST_CRD: state <= ST_CWR;
        ST_CWR: begin
          d_ptr <= d_ptr + AW'(1);
          widx  <= widx + 16'd1;
          state <= (widx + 16'd1 == nwords) ? ST_SDONE : ST_CRD;
        end
        ST_SDONE: begin
          acc    <= acc + s_cnt;
          src_rd <= IDX_W'(ring_step(16'(src_rd), 16'(src_mask)));
          state  <= s_gather ? ST_IDLE : ST_WB;
        end
        ST_WB: begin
          dst_rd    <= IDX_W'(ring_step(16'(dst_rd), 16'(dst_mask)));
          d_open    <= 1'b0;
          copy_done <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ce_copy_engine.sv
module ce_copy_engine
  import ce_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          copy_done,
  output logic          err_flag
);
  logic [AW-1:0]    src_base, dst_base;
  logic [IDX_W-1:0] src_mask, dst_mask, src_wr, dst_wr, src_rd, dst_rd;
  logic [15:0]      max_len;
  logic             err_set, err_clr, busy, wb_fire;

  ce_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_rd(src_rd), .dst_rd(dst_rd), .err_set(err_set),
    .src_base(src_base), .dst_base(dst_base),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_wr(src_wr), .dst_wr(dst_wr),
    .max_len(max_len), .err_flag(err_flag), .err_clr(err_clr)
  );

  ce_ring_walker #(.AW(AW), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .src_base(src_base), .dst_base(dst_base),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_wr(src_wr), .dst_wr(dst_wr), .max_len(max_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .src_rd(src_rd), .dst_rd(dst_rd),
    .copy_done(copy_done), .err_set(err_set),
    .busy(busy), .wb_fire(wb_fire)
  );
endmodule

// File: rtl/ce_copy_engine_chk.sv
module ce_copy_engine_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             copy_done,
  input logic             wb_fire,
  input logic             busy,
  input logic             err_flag,
  input logic             err_clr,
  input logic [IDX_W-1:0] src_rd,
  input logic [IDX_W-1:0] src_wr,
  input logic [IDX_W-1:0] dst_rd,
  input logic [IDX_W-1:0] src_mask,
  input logic [IDX_W-1:0] dst_mask
);
  // R7
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> $past(wb_fire));

  // R7
  done_moves_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> dst_rd == (($past(dst_rd) + IDX_W'(1)) & $past(dst_mask)));

  // R7
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_done |-> dst_rd == $past(dst_rd));

  // R8
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd != $past(src_rd)) |-> src_rd == (($past(src_rd) + IDX_W'(1)) & $past(src_mask)));

  // R3
  start_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ($past(src_rd) != $past(src_wr)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_flag) && !$past(err_clr)) |-> err_flag);
endmodule

bind ce_copy_engine ce_copy_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .copy_done(copy_done), .wb_fire(wb_fire),
  .busy(busy), .err_flag(err_flag), .err_clr(err_clr),
  .src_rd(src_rd), .src_wr(src_wr), .dst_rd(dst_rd),
  .src_mask(src_mask), .dst_mask(dst_mask)
);

// File: tb/ce_copy_engine_tb.sv
module ce_copy_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic        copy_done, err_flag;

  logic [31:0] mem [0:1023];
  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int s_wr = 0;
  int d_wr = 0;
  bit finished = 0;

  localparam int SB = 'h000;
  localparam int DB = 'h010;

  always #5 clk = ~clk;

  ce_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .copy_done(copy_done), .err_flag(err_flag)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_req && mem_we)  mem[mem_addr[9:0]] = mem_wdata;
  end

  always @(posedge clk) if (rst_n && copy_done) done_cnt++;

  function automatic logic [31:0] rev_bytes(logic [31:0] w);
    return {<<8{w}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic post_src(input int addr, input int cnt, input logic [15:0] flg);
    mem[SB + 2*s_wr]     = addr;
    mem[SB + 2*s_wr + 1] = {flg, cnt[15:0]};
    s_wr = (s_wr + 1) % 4;
  endtask

  task automatic post_dst(input int addr);
    mem[DB + 2*d_wr]     = addr;
    mem[DB + 2*d_wr + 1] = 32'h0;
    d_wr = (d_wr + 1) % 4;
  endtask

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int dc;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
    for (int i = 0; i < 128; i++) mem['h100 + i] = 32'h11223344 + i * 32'h01030507;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rreg(4'd3, v); chk("R1 src rd", v, 0);
    rreg(4'd7, v); chk("R1 dst rd", v, 0);
    rreg(4'd2, v); chk("R1 src wr", v, 0);
    rreg(4'd9, v); chk("R1 status", v, 0);
    rreg(4'd1, v); chk("R1 size", v, 1);
    chk("R1 copy_done", 32'(copy_done), 0);

    // R11 setup and readback
    wreg(4'd0, SB); wreg(4'd1, 4); wreg(4'd4, DB); wreg(4'd5, 4); wreg(4'd8, 64);
    rreg(4'd4, v); chk("R11 dst base", v, DB);
    rreg(4'd8, v); chk("R11 max len", v, 64);

    // R4 R2: plain 12-byte copy, transfer id set in upper flags
    post_src('h100, 12, 16'hABC0);
    post_dst('h200);
    wreg(4'd6, d_wr); wreg(4'd2, s_wr);
    settle();
    for (int i = 0; i < 3; i++) chk("R4 plain data", mem['h200 + i], mem['h100 + i]);
    chk("R4 no overrun", mem['h203], 32'hDEADBEEF);
    chk("R7 length", mem[DB + 1], 12);
    rreg(4'd7, v); chk("R7 dst rd", v, 1);
    rreg(4'd3, v); chk("R8 src rd", v, 1);
    chk("R7 one done", done_cnt, 1);

    // R5: swap with 6 bytes (2 words)
    post_src('h110, 6, 16'h0002);
    post_dst('h210);
    wreg(4'd6, d_wr); wreg(4'd2, s_wr);
    settle();
    chk("R5 swap w0", mem['h210], rev_bytes(mem['h110]));
    chk("R5 swap w1", mem['h211], rev_bytes(mem['h111]));
    chk("R4 round words", mem['h212], 32'hDEADBEEF);
    chk("R7 length 6", mem[DB + 3], 6);

    // R6: gather two fragments, source ring wraps
    post_src('h120, 8, 16'h0001);
    post_src('h130, 4, 16'h0000);
    post_dst('h220);
    wreg(4'd6, d_wr); wreg(4'd2, s_wr);
    settle();
    chk("R6 frag0 w0", mem['h220], mem['h120]);
    chk("R6 frag0 w1", mem['h221], mem['h121]);
    chk("R6 frag1 w0", mem['h222], mem['h130]);
    chk("R6 total len", mem[DB + 5], 12);
    chk("R6 single completion", done_cnt, 3);
    rreg(4'd3, v); chk("R9 src wrap", v, 0);
    rreg(4'd7, v); chk("R7 dst rd 3", v, 3);

    // R3: source pending, no destination buffer
    post_src('h140, 4, 16'h0000);
    wreg(4'd2, s_wr);
    settle();
    rreg(4'd3, v); chk("R3 src held", v, 0);
    chk("R3 no completion", done_cnt, 3);
    post_dst('h230);
    wreg(4'd6, d_wr);
    settle();
    rreg(4'd3, v); chk("R3 src moved", v, 1);
    rreg(4'd7, v); chk("R9 dst wrap", v, 0);
    chk("R3 data", mem['h230], mem['h140]);

    // R10: over-length descriptor skipped
    dc = done_cnt;
    post_dst('h240);
    wreg(4'd6, d_wr);
    post_src('h150, 100, 16'h0000);
    wreg(4'd2, s_wr);
    settle();
    chk("R10 err out", 32'(err_flag), 1);
    rreg(4'd9, v); chk("R10 status", v, 1);
    rreg(4'd3, v); chk("R10 src skipped", v, 2);
    rreg(4'd7, v); chk("R10 dst held", v, 0);
    chk("R10 dst untouched", mem['h240], 32'hDEADBEEF);
    chk("R10 no done", done_cnt, dc);
    repeat (10) @(negedge clk);
    chk("R10 sticky", 32'(err_flag), 1);
    wreg(4'd9, 1);
    rreg(4'd9, v); chk("R10 cleared", v, 0);
    post_src('h150, 4, 16'h0000);
    wreg(4'd2, s_wr);
    settle();
    chk("R10 next ok", mem['h240], mem['h150]);
    rreg(4'd7, v); chk("R10 dst rd", v, 1);

    // R9: write index masked by size-1
    wreg(4'd2, 32'hFFFF_FFF3);
    rreg(4'd2, v); chk("R9 wr masked", v, 3);
    settle();
    rreg(4'd3, v); chk("R9 src idle", v, 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule